// File: doc/BRIEF.md
# PCI configuration space register file

This block is the 256-byte configuration register space of a single PCI function. An upstream config access port presents an 8-bit byte offset, a byte length of 1, 2 or 4, 32-bit write data and a write strobe. The block returns the addressed bytes assembled little-endian on a combinational read port, and on a strobed write it updates the writable bytes that the access covers.

Six base address registers and an expansion-ROM base register each have their own size parameter. A full 32-bit write to one of them is masked to the region's size alignment. Software can therefore write all ones and read back the size mask. The low type bits of each base register are fixed: bit 0 set means an I/O region and clear means a memory region. The ROM register keeps its enable bit in bit 0.

Identity fields (vendor, device, revision, class code, header type, interrupt pin) come from parameters and ignore writes. Any write that covers the command register raises a one-cycle pulse on the next cycle, so that the address-window logic downstream re-evaluates its decode.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, the command register (0x04–0x05), cache-line byte (0x0C), latency byte (0x0D) and interrupt-line byte (0x3C) read zero. Base registers read only their type bits, and the ROM register reads zero.
- R2: The identity fields are read-only and always return their parameter values. These are the vendor ID at 0x00–0x01, the device ID at 0x02–0x03, the revision at 0x08, the class code at 0x09–0x0B, the header type at 0x0E and the interrupt pin at 0x3D.
- R3: A write of length 4 at base register n (offset 0x10+4n, n = 0..5) with offset bits [1:0] = 0 stores the write data ANDed with ~(size−1). The register then reads back that value ORed with its type, which is bit 0 = 1 for I/O and the low four bits = 0 for memory.
- R4: A base register or the ROM register ignores any write whose length is not 4 or whose offset is not the register's aligned first byte.
- R5: A length-4 write at 0x30 stores the data ANDed with ~(ROM size−1), and bit 0 (the enable) is always kept. All other bits below the size alignment read zero.
- R6: A base register whose size parameter is 0 reads zero whatever is written to it.
- R7: A read of length L (1, 2 or 4) at offset A returns the byte at (A+i) mod 256 in bits [8i+7:8i] for i < L. Higher bytes read zero.
- R8: Writes of any valid length update the writable bytes they cover, one byte at a time: 0x04, 0x05, 0x0C, 0x0D and 0x3C.
- R9: `win_update` is high for exactly the one cycle after a valid write that covers byte 0x04 or 0x05, counting wrapped bytes. It is low otherwise.
- R10: An access length other than 1, 2 or 4 returns zero read data, and a write with such a length changes nothing.
- R11: Every other offset, including the status word, BIST, 0x28–0x2F, 0x34–0x3B, 0x3E–0x3F and 0x40–0xFF, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the current access |
| cfg_off | input | 8 | Byte offset of the access |
| cfg_len | input | 3 | Access length in bytes (1, 2 or 4 valid) |
| cfg_wdata | input | 32 | Write data, byte i goes to offset+i |
| cfg_rdata | output | 32 | Little-endian read data for offset/length |
| win_update | output | 1 | One-cycle pulse after a write covering the command register |

## Verification
The assertions check the following on every cycle:
- the base-register store rule and the hold of each base register when it is not hit;
- that bits below the size alignment always equal the type bits;
- the exact timing of the command-touch pulse;
- zero read data for illegal lengths;
- the zeroed upper bytes on short reads.

Only the bench scenarios can show that identity and unimplemented bytes really ignore writes, and that partial or misaligned writes leave the base registers unchanged. The same holds for the little-endian assembly and wrap at offset 0xFF and for the read-back of size masks after all-ones writes. For that, the bench sweeps every offset at every legal length against a model built from the requirements.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int          NUM_BAR   = 6;
  localparam logic [7:0]  OFS_BAR0  = 8'h10;
  localparam logic [7:0]  OFS_ROM   = 8'h30;

  // legal access lengths are 1, 2 and 4 bytes
  function automatic logic len_ok(input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction

  // bits a region register keeps from a write
  function automatic logic [31:0] size_keep(input logic [31:0] sz, input logic rom);
    if (sz == 32'd0) return 32'd0;
    return ~(sz - 32'd1) | {31'd0, rom};
  endfunction

  // fixed low bits describing the region kind
  function automatic logic [31:0] type_bits(input logic is_io);
    return {31'd0, is_io};
  endfunction

  // bytes that accept ordinary byte-granular writes
  function automatic logic byte_writable(input logic [7:0] a);
    return (a == 8'h04) || (a == 8'h05) || (a == 8'h0C) ||
           (a == 8'h0D) || (a == 8'h3C);
  endfunction

endpackage

// File: rtl/cfgsp_bar.sv
module cfgsp_bar
  import cfgsp_pkg::*;
#(
  parameter logic [31:0] SIZE   = 32'd16,
  parameter bit          IS_IO  = 1'b0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val
);

  localparam logic [31:0] KEEP  = size_keep(SIZE, IS_ROM);
  localparam logic [31:0] RTYPE = (SIZE == 32'd0 || IS_ROM) ? 32'd0 : type_bits(IS_IO);

  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= 32'd0;
    else if (wr_hit) base_q <= wdata & KEEP;
  end

  assign rd_val = base_q | RTYPE;

  // R3 R5 R6
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rd_val == (($past(wdata) & KEEP) | RTYPE));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(rd_val));

  // R3 R5 R6
  lowbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_val & ~KEEP) == RTYPE);

endmodule

// File: rtl/cfgsp_rdmux.sv
module cfgsp_rdmux
  import cfgsp_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic [WORDS*32-1:0]           words,
  input  logic [$clog2(WORDS*4)-1:0]    off,
  input  logic [2:0]                    len,
  output logic [31:0]                   rdata
);

  localparam int AW = $clog2(WORDS * 4);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [AW-1:0] addr;
    logic [7:0]    data;
    assign addr = off + AW'(i);
    assign data = words[{addr, 3'b000} +: 8];
    assign rdata[8*i +: 8] = (len_ok(len) && (3'(i) < len)) ? data : 8'h00;
  end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfgsp_pkg::*;
#(
  parameter logic [15:0]          VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0]          DEVICE_ID  = 16'h0A17,
  parameter logic [7:0]           REVISION   = 8'h03,
  parameter logic [23:0]          CLASS_CODE = 24'h020000,
  parameter logic [7:0]           HDR_TYPE   = 8'h00,
  parameter logic [7:0]           INT_PIN    = 8'h01,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES = {32'h0010_0000, 32'd4, 32'd16,
                                                32'd0, 32'd16, 32'd4096},
  parameter logic [NUM_BAR-1:0]   BAR_IS_IO  = 6'b010010,
  parameter logic [31:0]          ROM_SIZE   = 32'd2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_off,
  input  logic [2:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        win_update
);

  localparam int WORDS = 64;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic        win_q;

  // ---- byte-granular write lanes ----
  logic [7:0] b_addr [4];
  logic       b_en   [4];
  logic       cmd_touch;

  always_comb begin
    cmd_touch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      b_addr[i] = cfg_off + 8'(i);
      b_en[i]   = cfg_wr && len_ok(cfg_len) && (3'(i) < cfg_len);
      if (b_en[i] && (b_addr[i] == 8'h04 || b_addr[i] == 8'h05)) cmd_touch = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 16'd0;
      cls_q  <= 8'd0;
      lat_q  <= 8'd0;
      intl_q <= 8'd0;
      win_q  <= 1'b0;
    end else begin
      win_q <= cmd_touch;
      for (int i = 0; i < 4; i++) begin
        if (b_en[i] && byte_writable(b_addr[i])) begin
          case (b_addr[i])
            8'h04:   cmd_q[7:0]  <= cfg_wdata[8*i +: 8];
            8'h05:   cmd_q[15:8] <= cfg_wdata[8*i +: 8];
            8'h0C:   cls_q       <= cfg_wdata[8*i +: 8];
            8'h0D:   lat_q       <= cfg_wdata[8*i +: 8];
            default: intl_q      <= cfg_wdata[8*i +: 8];
          endcase
        end
      end
    end
  end

  assign win_update = win_q;

  // ---- region registers: full aligned words only ----
  logic        wr_full;
  logic [31:0] bar_rd [NUM_BAR];
  logic [31:0] rom_rd;

  assign wr_full = cfg_wr && (cfg_len == 3'd4) && (cfg_off[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
    cfgsp_bar #(
      .SIZE   (BAR_SIZES[g*32 +: 32]),
      .IS_IO  (BAR_IS_IO[g]),
      .IS_ROM (1'b0)
    ) u_bar (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_full && (cfg_off == OFS_BAR0 + 8'(4*g))),
      .wdata  (cfg_wdata),
      .rd_val (bar_rd[g])
    );
  end

  cfgsp_bar #(
    .SIZE   (ROM_SIZE),
    .IS_IO  (1'b0),
    .IS_ROM (1'b1)
  ) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_full && (cfg_off == OFS_ROM)),
    .wdata  (cfg_wdata),
    .rd_val (rom_rd)
  );

  // ---- word view of the space ----
  logic [WORDS*32-1:0] words;

  always_comb begin
    words = '0;
    words[0*32 +: 32]  = {DEVICE_ID, VENDOR_ID};
    words[1*32 +: 32]  = {16'h0000, cmd_q};
    words[2*32 +: 32]  = {CLASS_CODE, REVISION};
    words[3*32 +: 32]  = {8'h00, HDR_TYPE, lat_q, cls_q};
    for (int n = 0; n < NUM_BAR; n++) words[(4+n)*32 +: 32] = bar_rd[n];
    words[12*32 +: 32] = rom_rd;
    words[15*32 +: 32] = {16'h0000, INT_PIN, intl_q};
  end

  cfgsp_rdmux #(.WORDS(WORDS)) u_rdmux (
    .words (words),
    .off   (cfg_off),
    .len   (cfg_len),
    .rdata (cfg_rdata)
  );

  // R9
  win_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_touch |=> win_update);

  // R9
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_touch |=> !win_update);

  // R10
  badlen_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_ok(cfg_len) |-> cfg_rdata == 32'd0);

  // R7
  short_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len == 3'd1 || cfg_len == 3'd2) |-> cfg_rdata[31:16] == 16'd0);

  // R8
  intl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_len == 3'd1 && cfg_off == 8'h3C) |=> intl_q == $past(cfg_wdata[7:0]));

endmodule

// File: tb/sim_cfg_space_regfile.sv
`timescale 1ns/1ps
module sim_cfg_space_regfile;

  localparam logic [15:0]  VEN  = 16'h1234;
  localparam logic [15:0]  DEV  = 16'h5678;
  localparam logic [7:0]   REV  = 8'h9A;
  localparam logic [23:0]  CLS  = 24'h0C0320;
  localparam logic [7:0]   HDR  = 8'h80;
  localparam logic [7:0]   PIN  = 8'h02;
  localparam logic [191:0] BSZ  = {32'h0010_0000, 32'd4, 32'd16, 32'd0, 32'd16, 32'd4096};
  localparam logic [5:0]   BIO  = 6'b010010;
  localparam logic [31:0]  RSZ  = 32'd2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_off = 8'd0;
  logic [2:0]  cfg_len = 3'd1;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        win_update;

  always #4 clk = ~clk;

  cfg_space_regfile #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .CLASS_CODE(CLS),
    .HDR_TYPE(HDR), .INT_PIN(PIN), .BAR_SIZES(BSZ), .BAR_IS_IO(BIO),
    .ROM_SIZE(RSZ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
    .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .win_update(win_update)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // ---- model state (raw written data, masked on read) ----
  logic [31:0] m_bar [6];
  logic [31:0] m_rom;
  logic [15:0] m_cmd;
  logic [7:0]  m_cls, m_lat, m_intl;

  function automatic logic [31:0] bsize(input int n);
    return BSZ[n*32 +: 32];
  endfunction

  function automatic logic [31:0] bar_exp(input int n);
    logic [31:0] sz = bsize(n);
    if (sz == 0) return 32'd0;
    return (m_bar[n] - (m_bar[n] % sz)) | {31'd0, BIO[n]};
  endfunction

  function automatic logic [31:0] rom_exp();
    return (m_rom - (m_rom % RSZ)) | {31'd0, m_rom[0]};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    logic [31:0] w;
    case (a[7:2])
      6'd0:  w = {DEV, VEN};
      6'd1:  w = {16'h0, m_cmd};
      6'd2:  w = {CLS, REV};
      6'd3:  w = {8'h0, HDR, m_lat, m_cls};
      6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9: w = bar_exp(int'(a[7:2]) - 4);
      6'd12: w = rom_exp();
      6'd15: w = {16'h0, PIN, m_intl};
      default: w = 32'd0;
    endcase
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] off, input logic [2:0] len);
    logic [31:0] r = 32'd0;
    if (len != 1 && len != 2 && len != 4) return 32'd0;
    for (int i = 0; i < 4; i++)
      if (i < int'(len)) r[8*i +: 8] = exp_byte(off + 8'(i));
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < 6; n++) m_bar[n] = 32'd0;
    m_rom = 0; m_cmd = 0; m_cls = 0; m_lat = 0; m_intl = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_read(input logic [7:0] off, input logic [2:0] len, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_off = off; cfg_len = len;
    #1;
    e = exp_read(off, len);
    chk(cfg_rdata == e, $sformatf("%s read off=%02h len=%0d", tag, off, len), cfg_rdata, e);
  endtask

  task automatic do_write(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
    bit ok_len = (len == 1 || len == 2 || len == 4);
    bit touch = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = off; cfg_len = len; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (ok_len)
      for (int i = 0; i < int'(len); i++) begin
        logic [7:0] a = off + 8'(i);
        if (a == 8'h04 || a == 8'h05) touch = 1'b1;
      end
    // R9: pulse one cycle after the write edge
    chk(win_update == touch, $sformatf("R9 win_update after write off=%02h len=%0d", off, len),
        {31'd0, win_update}, {31'd0, touch});
    if (ok_len) begin
      if (len == 4 && off[1:0] == 0 && off >= 8'h10 && off <= 8'h24)
        m_bar[(off - 8'h10) >> 2] = d;
      else if (len == 4 && off == 8'h30)
        m_rom = d;
      for (int i = 0; i < int'(len); i++) begin
        logic [7:0] a = off + 8'(i);
        case (a)
          8'h04: m_cmd[7:0]  = d[8*i +: 8];
          8'h05: m_cmd[15:8] = d[8*i +: 8];
          8'h0C: m_cls       = d[8*i +: 8];
          8'h0D: m_lat       = d[8*i +: 8];
          8'h3C: m_intl      = d[8*i +: 8];
          default: ;
        endcase
      end
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) do_read(8'(a), 3'd1, tag);
  endtask

  task automatic full_sweep();
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), 3'd2, "R7 R11 half");
      do_read(8'(a), 3'd4, "R7 R11 word");
    end
  endtask

  task automatic region_read_all(input string tag);
    for (int n = 0; n < 6; n++) do_read(8'h10 + 8'(4*n), 3'd4, tag);
    do_read(8'h30, 3'd4, tag);
  endtask

  initial begin
    model_reset();
    do_reset();

    // R1 R2 R11: reset image of every byte
    sweep("R1 R2 R11 reset");

    // R3 R5 R6: all-ones size discovery
    for (int n = 0; n < 6; n++) do_write(8'h10 + 8'(4*n), 3'd4, 32'hFFFF_FFFF);
    do_write(8'h30, 3'd4, 32'hFFFF_FFFF);
    region_read_all("R3 R5 R6 all-ones");

    // R3 R5: other patterns, ROM enable clear and set
    for (int n = 0; n < 6; n++) do_write(8'h10 + 8'(4*n), 3'd4, 32'hA5A5_5A5A);
    do_write(8'h30, 3'd4, 32'h1234_5678);
    region_read_all("R3 R5 pattern");
    do_write(8'h30, 3'd4, 32'h8765_4321);
    do_read(8'h30, 3'd4, "R5 rom enable kept");

    // R4: partial and misaligned writes to region registers ignored
    do_write(8'h10, 3'd2, 32'h0000_0000);
    do_write(8'h14, 3'd1, 32'h0000_0000);
    do_write(8'h11, 3'd4, 32'h0000_0000);
    do_write(8'h32, 3'd2, 32'h0000_0000);
    do_write(8'h2E, 3'd4, 32'h0000_0000);
    region_read_all("R4 partial ignored");

    // R2 R11: identity and reserved bytes ignore writes
    do_write(8'h00, 3'd4, 32'hFFFF_FFFF);
    do_write(8'h08, 3'd4, 32'hFFFF_FFFF);
    do_write(8'h0E, 3'd2, 32'hFFFF_FFFF);
    do_write(8'h3D, 3'd1, 32'hFFFF_FFFF);
    do_write(8'h40, 3'd4, 32'hFFFF_FFFF);
    do_write(8'h28, 3'd4, 32'hFFFF_FFFF);
    do_read(8'h00, 3'd4, "R2 ids");
    do_read(8'h08, 3'd4, "R2 class");
    do_read(8'h0C, 3'd4, "R2 header");
    do_read(8'h3C, 3'd4, "R2 pin");
    do_read(8'h40, 3'd4, "R11 reserved");
    do_read(8'h28, 3'd4, "R11 reserved");

    // R8 R9: writable bytes via several lengths and wraps
    do_write(8'h04, 3'd4, 32'hDEAD_BEEF);
    do_write(8'h03, 3'd2, 32'h0000_7700);
    do_write(8'h06, 3'd1, 32'h0000_00FF);
    do_write(8'hFF, 3'd2, 32'h0000_FFFF);
    do_write(8'h02, 3'd4, 32'h0055_66AA);
    do_write(8'h0C, 3'd2, 32'h0000_3C1E);
    do_write(8'h3C, 3'd1, 32'h0000_000B);
    do_write(8'h3B, 3'd4, 32'h0000_C900);
    do_read(8'h04, 3'd2, "R8 command");
    do_read(8'h0C, 3'd4, "R8 cache latency");
    do_read(8'h3C, 3'd1, "R8 int line");

    // R10: illegal lengths
    do_write(8'h04, 3'd3, 32'h1111_1111);
    do_write(8'h3C, 3'd0, 32'h2222_2222);
    do_write(8'h10, 3'd7, 32'h3333_3333);
    do_read(8'h00, 3'd3, "R10 len3");
    do_read(8'h04, 3'd0, "R10 len0");
    do_read(8'h04, 3'd2, "R10 no write");

    // R7: wrap at top of space
    do_read(8'hFF, 3'd4, "R7 wrap");
    do_read(8'hFE, 3'd2, "R7 edge");

    full_sweep();

    // R1: reset after traffic
    do_reset();
    sweep("R1 second reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule